// File: doc/BRIEF.md
# Software Watchdog Timer with Prescaled Timeout

This block is a software watchdog. It counts system clock cycles and, unless software services it in time, raises a single-cycle reset request together with a sticky timeout flag. Software reaches it through a small register write port with two addresses. The control register holds an enable bit, a prescale bit and a two-bit timeout select. The service register accepts the two keys that restart the count.

Servicing is a two-key handshake: the first key and then the second key are written to the service address. Any number of unrelated writes may fall between the two keys. A completed handshake clears the prescaler and the main counter. It also loads the timeout select that software last wrote, so a new period only applies after the next service. The prescale bit divides the count clock by a power of two (512 by default). Its reset value follows a mode pin that is sampled while reset is held.

Top module: `svc_watchdog`

## Requirements
- R1: Writing 8'h55 and then 8'hAA to the service address (wr_addr = 1) completes a service. This clears both counters, so the next rst_req comes exactly one full period after the edge that captured 8'hAA.
- R2: Writes to the control address, and writes of other values to the service address, may fall between 8'h55 and 8'hAA without breaking the sequence.
- R3: 8'hAA written without an earlier 8'h55 does not service the watchdog. Any value other than the two keys leaves the sequence state unchanged.
- R4: With prescale off, select values 0, 1, 2 and 3 give periods of 2^B, 2^(B+2), 2^(B+4) and 2^(B+6) clocks, where B = BASE_EXP (default 9).
- R5: With prescale on, each period is multiplied by 2^PRE_EXP (default 9, giving 2^18 to 2^24 clocks).
- R6: A control write stores the select (bits [3:2]) as pending only. The counter keeps the active select, which is 0 after reset, until the next completed service.
- R7: The control register is at wr_addr = 0 with bit 0 = enable, bit 1 = prescale and bits [3:2] = select, and it reads back on ctrl_rd in the same layout. Reset gives enable 1, select 0 and prescale equal to the inverse of mode_pin. Software may rewrite prescale afterwards.
- R8: rst_req is high for exactly one cycle, in the cycle after the period-th counting edge. The counters then restart, so requests repeat every period.
- R9: timeout_flag is set with the first rst_req and stays set until a system reset.
- R10: While enable is 0, the counters are held at zero and no rst_req is raised. After re-enabling, a full period elapses before the next request.
- R11: A service completed on the same edge at which the count would expire wins. No request is raised and a new period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| mode_pin | input | 1 | Mode level sampled during reset; low selects prescale on |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control register, 1 = service register |
| wr_data | input | 8 | Write data |
| ctrl_rd | output | 4 | Control register readback {select, prescale, enable} |
| rst_req | output | 1 | One-cycle reset request on timeout |
| timeout_flag | output | 1 | Sticky timeout status |

## Verification
A write is captured at the clock edge that follows the cycle in which it is driven. After the edge that completes a service, rst_req is due exactly P edges later, where P is the selected period in clocks. Control readback and the timeout flag change one edge after their cause. The bench drives inputs on falling edges, samples on falling edges and counts rising edges from a known clearing edge, so every expected cycle count is exact rather than bounded. It runs with a small base and prescale exponent, so that every prescale and select combination can be swept and timed against the arithmetic periods.

// File: rtl/swdog_pkg.sv
// Package: shared constants and types for the software watchdog.
// Assumes a one-bit register address space: control and service.
package swdog_pkg;

    localparam logic       ADDR_CTRL  = 1'b0;
    localparam logic       ADDR_SVC   = 1'b1;
    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;
    localparam int         SEL_W      = 2;
    localparam int         SEL_SPAN   = 2 * ((1 << SEL_W) - 1);

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             prescale;
        logic             enable;
    } ctrl_t;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_state_t;

endpackage

// File: rtl/swdog_regs.sv
// Module: control register and active timeout select.
// Holds enable, prescale and pending select. The active select loads
// from the pending value only when a service completes. Assumes a
// control write and a service completion never share an edge
// (there is a single write port).
module swdog_regs
    import swdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_pin,
    input  logic             ctrl_we,
    input  logic [3:0]       ctrl_wdata,
    input  logic             svc_done,
    output ctrl_t            ctrl_q,
    output logic [SEL_W-1:0] act_sel
);

    // Control register: reset loads prescale from mode pin, writes replace all fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.enable   <= 1'b1;
            ctrl_q.prescale <= ~mode_pin;
            ctrl_q.sel      <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= ctrl_t'(ctrl_wdata);
        end
    end

    // Active select: adopts the pending select on each completed service.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_sel <= '0;
        end else if (svc_done) begin
            act_sel <= ctrl_q.sel;
        end
    end

endmodule

// File: rtl/swdog_keyseq.sv
// Module: service key sequence checker.
// Arms on the first key, completes on the second key while armed.
// Other values leave the state alone. The completion pulse is
// combinational, in the cycle the second key is presented.
module swdog_keyseq
    import swdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       svc_we,
    input  logic [7:0] svc_data,
    output logic       svc_done
);

    seq_state_t state_q;
    logic       is_first;
    logic       is_second;

    // Key decode for the presented service write.
    always_comb begin
        is_first  = svc_we && (svc_data == KEY_FIRST);
        is_second = svc_we && (svc_data == KEY_SECOND);
        svc_done  = is_second && (state_q == SEQ_ARMED);
    end

    // Sequence state: first key arms, second key while armed disarms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else if (is_first) begin
            state_q <= SEQ_ARMED;
        end else if (svc_done) begin
            state_q <= SEQ_IDLE;
        end
    end

endmodule

// File: rtl/swdog_count.sv
// Module: prescaler, main counter and expiry detection.
// The prescaler divides by 2**PRE_EXP when prescale is on; otherwise
// every clock is a tick. The main counter expires after
// 2**(BASE_EXP + 2*sel) ticks. A clear or a low enable zeroes both
// counters, and a clear on the expiry edge suppresses the request.
module swdog_count
    import swdog_pkg::*;
#(
    parameter int BASE_EXP = 9,
    parameter int PRE_EXP  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             prescale,
    input  logic [SEL_W-1:0] act_sel,
    input  logic             clear,
    output logic             expire,
    output logic             expired_seen
);

    localparam int MAIN_W = BASE_EXP + SEL_SPAN;

    logic [PRE_EXP-1:0] pre_q;
    logic [MAIN_W-1:0]  main_q;
    logic [MAIN_W-1:0]  last_cnt;
    logic [2:0]         drop_sh;
    logic               tick;
    logic               at_last;

    // Terminal count for the active select and the tick strobe.
    always_comb begin
        drop_sh  = 3'(SEL_SPAN) - {act_sel, 1'b0};
        last_cnt = {MAIN_W{1'b1}} >> drop_sh;
        tick     = ~prescale | (&pre_q);
        at_last  = (main_q == last_cnt);
    end

    // Prescaler: runs only while enabled with prescale on.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !enable || !prescale) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // Main counter: advances on ticks and wraps at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !enable) begin
            main_q <= '0;
        end else if (tick) begin
            main_q <= at_last ? '0 : main_q + 1'b1;
        end
    end

    // Expiry pulse and sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expire       <= 1'b0;
            expired_seen <= 1'b0;
        end else begin
            expire <= enable && !clear && tick && at_last;
            if (enable && !clear && tick && at_last) begin
                expired_seen <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/svc_watchdog.sv
// Module: software watchdog top level.
// Decodes the two-address write port, joins the control register,
// the key sequence checker and the counter. BASE_EXP sets the
// shortest period exponent and PRE_EXP the prescale exponent.
module svc_watchdog
    import swdog_pkg::*;
#(
    parameter int BASE_EXP = 9,
    parameter int PRE_EXP  = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_pin,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    output logic [3:0] ctrl_rd,
    output logic       rst_req,
    output logic       timeout_flag
);

    ctrl_t            ctrl_q;
    logic [SEL_W-1:0] act_sel;
    logic             ctrl_we;
    logic             svc_we;
    logic             svc_done;

    // Address decode of the write port.
    always_comb begin
        ctrl_we = wr_en && (wr_addr == ADDR_CTRL);
        svc_we  = wr_en && (wr_addr == ADDR_SVC);
        ctrl_rd = ctrl_q;
    end

    swdog_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_pin   (mode_pin),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (wr_data[3:0]),
        .svc_done   (svc_done),
        .ctrl_q     (ctrl_q),
        .act_sel    (act_sel)
    );

    swdog_keyseq u_keys (
        .clk      (clk),
        .rst_n    (rst_n),
        .svc_we   (svc_we),
        .svc_data (wr_data),
        .svc_done (svc_done)
    );

    swdog_count #(
        .BASE_EXP (BASE_EXP),
        .PRE_EXP  (PRE_EXP)
    ) u_count (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (ctrl_q.enable),
        .prescale     (ctrl_q.prescale),
        .act_sel      (act_sel),
        .clear        (svc_done),
        .expire       (rst_req),
        .expired_seen (timeout_flag)
    );

endmodule

// File: rtl/swdog_checker.sv
// Module: port-level properties of the software watchdog.
// Bound to svc_watchdog. All clocked properties are disabled in reset.
module swdog_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_pin,
    input logic [3:0] ctrl_rd,
    input logic       rst_req,
    input logic       timeout_flag
);

    logic seen_q = 1'b0;
    logic in_rst_q;
    logic mode_q;

    // History of reset and mode pin for the reset-value check.
    always_ff @(posedge clk) begin
        seen_q   <= 1'b1;
        in_rst_q <= !rst_n;
        mode_q   <= mode_pin;
    end

    // R8: the request lasts one cycle.
    p_req_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R9: the flag accompanies every request.
    p_req_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> timeout_flag);

    // R9: the flag stays set outside reset.
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_flag |=> timeout_flag);

    // R10: no request follows a cycle with enable low.
    p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rd[0] |=> !rst_req);

    // R7: a reset edge loads prescale from the inverted mode level.
    always @(posedge clk) begin
        if (seen_q && in_rst_q) begin
            p_mode_reset_r7: assert (ctrl_rd[1] == !mode_q);
        end
    end

endmodule

bind svc_watchdog swdog_checker u_swdog_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_pin     (mode_pin),
    .ctrl_rd      (ctrl_rd),
    .rst_req      (rst_req),
    .timeout_flag (timeout_flag)
);

// File: tb/svc_watchdog_tb_top.sv
module svc_watchdog_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int B          = 2;
    localparam int PR         = 2;
    localparam int WAIT_LIMIT = 5000;
    localparam int CYC_LIMIT  = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_pin = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [3:0] ctrl_rd;
    logic       rst_req;
    logic       timeout_flag;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    svc_watchdog #(.BASE_EXP(B), .PRE_EXP(PR)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_pin     (mode_pin),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .ctrl_rd      (ctrl_rd),
        .rst_req      (rst_req),
        .timeout_flag (timeout_flag)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Cycle counter and watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > CYC_LIMIT) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, CYC_LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    function automatic int period(input int pres, input int sel);
        return 1 << (B + 2 * sel + (pres != 0 ? PR : 0));
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = 8'h00;
    endtask

    task automatic service();
        wr(1'b1, 8'h55);
        wr(1'b1, 8'hAA);
    endtask

    task automatic wait_req(output int n);
        n = 0;
        while (!rst_req && n < WAIT_LIMIT) begin
            @(negedge clk);
            n = n + 1;
        end
    endtask

    task automatic do_reset(input logic mode);
        mode_pin = mode;
        rst_n    = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int n;
        int hits;
        // R7: reset state with mode pin low
        @(negedge clk);
        do_reset(1'b0);
        chk("R7 ctrl_rd after reset, mode low", int'(ctrl_rd), 4'b0011);
        chk("R8 rst_req idle in reset", int'(rst_req), 0);
        chk("R9 flag clear after reset", int'(timeout_flag), 0);
        rst_n = 1'b1;
        // R5: default prescale on, select 0
        wait_req(n);
        chk("R5 default period after reset", n, period(1, 0));
        chk("R9 flag set with request", int'(timeout_flag), 1);
        @(negedge clk);
        chk("R8 request lasts one cycle", int'(rst_req), 0);

        // R7: software rewrites prescale
        wr(1'b0, 8'h01);
        chk("R7 prescale rewritten", int'(ctrl_rd), 4'b0001);

        // R4 and R5: sweep every prescale and select combination
        for (int p = 0; p < 2; p++) begin
            for (int s = 0; s < 4; s++) begin
                wr(1'b0, 8'((s << 2) | (p << 1) | 1));
                service();
                wait_req(n);
                chk(p != 0 ? "R5 period after service" : "R4 period after service",
                    n, period(p, s));
                @(negedge clk);
                chk("R8 pulse ends", int'(rst_req), 0);
                wait_req(n);
                chk("R8 repeat interval", n + 1, period(p, s));
            end
        end

        // R6: a select write without service keeps the old period
        wr(1'b0, 8'h01);
        service();
        wr(1'b0, 8'h0D);
        wait_req(n);
        @(negedge clk);
        wait_req(n);
        chk("R6 pending select not yet active", n + 1, period(0, 0));
        service();
        wait_req(n);
        chk("R6 select active after service", n, period(0, 3));

        // R2 and R1: writes between the keys, service restarts the count
        wr(1'b0, 8'h05);
        service();
        wr(1'b1, 8'h55);
        wr(1'b0, 8'h05);
        wr(1'b1, 8'h12);
        repeat (3) @(negedge clk);
        wr(1'b1, 8'hAA);
        wait_req(n);
        chk("R2 sequence survives other writes", n, period(0, 1));
        chk("R1 request due a full period after second key", n, 16);

        // R3: lone second key does not service
        service();
        wr(1'b1, 8'hAA);
        wr(1'b1, 8'h33);
        wait_req(n);
        chk("R3 lone second key ignored", n, period(0, 1) - 2);
        // R3: other values keep the armed state
        service();
        wr(1'b1, 8'h55);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'hAA);
        wait_req(n);
        chk("R3 armed state kept across other value", n, period(0, 1));

        // R11: service completing on the expiry edge wins
        service();
        repeat (period(0, 1) - 2) @(negedge clk);
        wr(1'b1, 8'h55);
        wr(1'b1, 8'hAA);
        chk("R11 no request on service edge", int'(rst_req), 0);
        wait_req(n);
        chk("R11 new period after late service", n, period(0, 1));

        // R10: disabled counter stays quiet, restarts from zero
        wr(1'b0, 8'h04);
        hits = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (rst_req) hits = hits + 1;
        end
        chk("R10 no request while disabled", hits, 0);
        wr(1'b0, 8'h05);
        wait_req(n);
        chk("R10 full period after enable", n, period(0, 1));

        // R9: flag persists across service, cleared by reset
        service();
        chk("R9 flag sticky after service", int'(timeout_flag), 1);
        do_reset(1'b1);
        chk("R9 flag cleared by reset", int'(timeout_flag), 0);
        chk("R7 ctrl_rd after reset, mode high", int'(ctrl_rd), 4'b0001);
        rst_n = 1'b1;
        wait_req(n);
        chk("R4 default period with prescale off", n, period(0, 0));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule